// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit fronts a small word-addressed shared memory that several requesters use at once. It provides indivisible primitives: exchange, test-and-set, compare-and-swap and fetch-and-increment. It also handles plain loads and stores. Each request gives an opcode, an address, an operand and a compare value. Each request gets one response with the word that memory held before the operation, a success bit and the identity of the requester.

A fixed-priority arbiter picks one requester at a time, and the lowest index wins. Once a request is accepted, the unit reads the word in one cycle and writes it in the next. No request is accepted until that write is done, so no other access can fall between the read and the write. Requesters that lose hold their request under a ready/valid stall.

Software builds spin locks on test-and-set, clearing the lock with a plain store of zero. It builds lock-free updates on compare-and-swap and shared counters on fetch-and-increment.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, every memory word reads as 0 and `rsp_valid` is low.
- R2: Opcode 0 (load) returns the stored word and leaves memory unchanged. Opcode 1 (store) writes the operand. Both return the previous word with success 1.
- R3: Opcode 2 (exchange) writes the operand, returns the previous word and reports success 1.
- R4: Opcode 3 (test-and-set) returns the previous word and always writes 1. Success is 1 exactly when the previous word was 0.
- R5: After a store of 0 to a lock word, the next test-and-set on that word returns 0 with success 1.
- R6: Opcode 4 (compare-and-swap) writes the operand only when the stored word equals the compare value. Success is 1 exactly when they matched, and the previous word is returned in every case.
- R7: Opcode 5 (fetch-and-increment) returns the previous word and stores that word plus one, wrapping modulo 2^DATA_W.
- R8: Opcodes 6 and 7 are reserved. They leave memory unchanged, return the previous word and report success 0.
- R9: When several requesters are valid while the unit is idle, only the lowest-numbered one sees `req_ready` high. The others stay stalled until they are accepted in turn.
- R10: For the two cycles after an acceptance, `req_ready` is low for every requester, so competing requests cannot reach memory between the read and the write.
- R11: Each accepted request produces exactly one response, with `rsp_valid` high for one cycle. The response appears three clock edges after the acceptance edge and carries the requester's index on `rsp_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_ready | output | N_REQ | Request accepted this cycle, one bit per requester |
| req_op | input | N_REQ*3 | Opcode per requester (3 bits each, requester i at bits 3i+2:3i) |
| req_addr | input | N_REQ*ADDR_W | Word address per requester |
| req_wdata | input | N_REQ*DATA_W | Operand or new value per requester |
| req_cmp | input | N_REQ*DATA_W | Compare value per requester |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_id | output | ID_W | Index of the requester being answered |
| rsp_rdata | output | DATA_W | Word held before the operation |
| rsp_ok | output | 1 | Success flag |

## Verification
The acceptance is combinational: `req_ready` reflects the current valid inputs in the same cycle. The response is due three clock edges after the acceptance edge, and `req_ready` must stay low on the two edges in between. The bench drives inputs on the falling edge and samples slightly later. Each time it sees an acceptance, it computes the result from its own memory image and queues the expected response with the cycle in which it is due. Every cycle it compares `req_ready` and the full response ports against the model, so an early, late, missing or extra response is caught in the exact cycle.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int N_REQ  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_REQ-1:0]          req_valid,
  output logic [N_REQ-1:0]          req_ready,
  input  logic [N_REQ*3-1:0]        req_op,
  input  logic [N_REQ*ADDR_W-1:0]   req_addr,
  input  logic [N_REQ*DATA_W-1:0]   req_wdata,
  input  logic [N_REQ*DATA_W-1:0]   req_cmp,
  output logic                      rsp_valid,
  output logic [((N_REQ>1)?$clog2(N_REQ):1)-1:0] rsp_id,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_ok
);
  localparam int ID_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam int DEPTH = 1 << ADDR_W;

  localparam logic [2:0] OP_LD  = 3'd0;
  localparam logic [2:0] OP_ST  = 3'd1;
  localparam logic [2:0] OP_SWP = 3'd2;
  localparam logic [2:0] OP_TAS = 3'd3;
  localparam logic [2:0] OP_CAS = 3'd4;
  localparam logic [2:0] OP_INC = 3'd5;

  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR} phase_t;
  phase_t phase;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, cmp_q, old_q;
  logic [ID_W-1:0]   id_q;

  logic [N_REQ-1:0]  gnt;
  logic [ID_W-1:0]   gid;
  logic              fire;

  always_comb begin
    gnt = '0;
    gid = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_valid[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        gid = ID_W'(i);
      end
    end
  end

  assign req_ready = (phase == PH_IDLE) ? gnt : '0;
  assign fire      = |(req_valid & req_ready);

  logic              we, ok;
  logic [DATA_W-1:0] nv;

  always_comb begin
    we = 1'b0;
    ok = 1'b1;
    nv = wd_q;
    case (op_q)
      OP_LD:  we = 1'b0;
      OP_ST:  we = 1'b1;
      OP_SWP: we = 1'b1;
      OP_TAS: begin we = 1'b1; nv = DATA_W'(1); ok = (old_q == '0); end
      OP_CAS: begin we = (old_q == cmp_q); ok = (old_q == cmp_q); end
      OP_INC: begin we = 1'b1; nv = old_q + DATA_W'(1); end
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      op_q      <= '0;
      addr_q    <= '0;
      wd_q      <= '0;
      cmp_q     <= '0;
      old_q     <= '0;
      id_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_rdata <= '0;
      rsp_ok    <= 1'b0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (phase)
        PH_IDLE: if (fire) begin
          op_q   <= req_op[gid*3 +: 3];
          addr_q <= req_addr[gid*ADDR_W +: ADDR_W];
          wd_q   <= req_wdata[gid*DATA_W +: DATA_W];
          cmp_q  <= req_cmp[gid*DATA_W +: DATA_W];
          id_q   <= gid;
          phase  <= PH_RD;
        end
        PH_RD: begin
          old_q <= mem[addr_q];
          phase <= PH_WR;
        end
        default: begin
          if (we) mem[addr_q] <= nv;
          rsp_valid <= 1'b1;
          rsp_rdata <= old_q;
          rsp_ok    <= ok;
          rsp_id    <= id_q;
          phase     <= PH_IDLE;
        end
      endcase
    end
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R10
  locked_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (req_ready == '0) ##1 (req_ready == '0));

  // R11
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ##3 rsp_valid);

  // R11
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  tas_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WR && op_q == OP_TAS) |=> mem[$past(addr_q)] == DATA_W'(1));

  // R7
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WR && op_q == OP_INC) |=> mem[$past(addr_q)] == rsp_rdata + DATA_W'(1));
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  localparam int N = 3, AW = 4, DW = 16, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid, req_ready;
  logic [N*3-1:0] req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata, req_cmp;
  logic rsp_valid, rsp_ok;
  logic [IW-1:0] rsp_id;
  logic [DW-1:0] rsp_rdata;

  atomic_rmw_unit #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, bz = 0;
  logic [DW-1:0] mm [16];
  bit pv [N];
  logic [2:0] s_op [N];
  logic [AW-1:0] s_ad [N];
  logic [DW-1:0] s_wd [N], s_cm [N];
  string s_tag [N];
  int q_due[$], q_id[$], q_dat[$], q_ok[$];
  string q_tag[$];

  task automatic chk(bit good, string tag, string what, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic post(int i, logic [2:0] op, int a, int w, int c, string tag);
    pv[i] = 1; s_op[i] = op; s_ad[i] = AW'(a); s_wd[i] = DW'(w); s_cm[i] = DW'(c); s_tag[i] = tag;
  endtask

  task automatic step();
    logic [N-1:0] er;
    int w;
    logic [DW-1:0] old;
    int ok;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      req_valid[i] = pv[i];
      req_op[i*3 +: 3] = s_op[i];
      req_addr[i*AW +: AW] = s_ad[i];
      req_wdata[i*DW +: DW] = s_wd[i];
      req_cmp[i*DW +: DW] = s_cm[i];
    end
    #2;
    er = '0; w = -1;
    if (bz == 0)
      for (int i = N - 1; i >= 0; i--) if (pv[i]) w = i;
    if (w >= 0) er[w] = 1'b1;
    chk(req_ready == er, "R9/R10", "req_ready", int'(req_ready), int'(er));
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      chk(rsp_valid == 1'b1, "R11", "rsp_valid", int'(rsp_valid), 1);
      chk(int'(rsp_id) == q_id[0], "R11", "rsp_id", int'(rsp_id), q_id[0]);
      chk(int'(rsp_rdata) == q_dat[0], q_tag[0], "rsp_rdata", int'(rsp_rdata), q_dat[0]);
      chk(int'(rsp_ok) == q_ok[0], q_tag[0], "rsp_ok", int'(rsp_ok), q_ok[0]);
      void'(q_due.pop_front()); void'(q_id.pop_front()); void'(q_dat.pop_front());
      void'(q_ok.pop_front()); void'(q_tag.pop_front());
    end else
      chk(rsp_valid == 1'b0, "R11", "rsp_valid", int'(rsp_valid), 0);
    if (w >= 0) begin
      old = mm[s_ad[w]]; ok = 1;
      case (s_op[w])
        3'd0: ;
        3'd1, 3'd2: mm[s_ad[w]] = s_wd[w];
        3'd3: begin mm[s_ad[w]] = 1; ok = (old == 0); end
        3'd4: begin ok = (old == s_cm[w]); if (ok != 0) mm[s_ad[w]] = s_wd[w]; end
        3'd5: mm[s_ad[w]] = old + 1'b1;
        default: ok = 0;
      endcase
      q_due.push_back(cyc + 3); q_id.push_back(w); q_dat.push_back(int'(old));
      q_ok.push_back(ok); q_tag.push_back(s_tag[w]);
      pv[w] = 0; bz = 2;
    end else if (bz > 0) bz--;
    cyc++;
  endtask

  task automatic drain();
    bit busy = 1;
    while (busy) begin
      step();
      busy = (q_due.size() > 0);
      for (int i = 0; i < N; i++) if (pv[i]) busy = 1;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) mm[k] = 0;
    for (int i = 0; i < N; i++) post(i, 0, 0, 0, 0, "R1");
    for (int i = 0; i < N; i++) pv[i] = 0;
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0; req_cmp = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin post(0, 0, a, 0, 0, "R1"); drain(); end
    post(1, 1, 1, 5, 0, "R2"); drain();
    post(1, 0, 1, 0, 0, "R2"); drain();
    post(2, 2, 1, 9, 0, "R3"); drain();
    post(0, 0, 1, 0, 0, "R3"); drain();
    post(0, 3, 2, 0, 0, "R4"); drain();
    post(1, 3, 2, 0, 0, "R4"); drain();
    post(0, 1, 2, 0, 0, "R5"); drain();
    post(2, 3, 2, 0, 0, "R5"); drain();
    post(0, 4, 3, 7, 0, "R6"); drain();
    post(1, 4, 3, 8, 0, "R6"); drain();
    post(1, 4, 3, 8, 7, "R6"); drain();
    post(0, 0, 3, 0, 0, "R6"); drain();
    post(0, 5, 4, 0, 0, "R7"); drain();
    post(0, 5, 4, 0, 0, "R7"); drain();
    post(2, 1, 5, 'hffff, 0, "R7"); drain();
    post(2, 5, 5, 0, 0, "R7"); drain();
    post(0, 0, 5, 0, 0, "R7"); drain();
    post(1, 6, 1, 'h1234, 'h9, "R8"); drain();
    post(1, 7, 1, 'h4321, 0, "R8"); drain();
    post(0, 0, 1, 0, 0, "R8"); drain();
    for (int i = N - 1; i >= 0; i--) post(i, 3, 6, 0, 0, "R9");
    drain();
    for (int i = 0; i < N; i++) post(i, 5, 7, 0, 0, "R10");
    drain();
    post(2, 5, 8, 0, 0, "R9"); step();
    post(0, 5, 8, 0, 0, "R9"); post(1, 2, 8, 'h55, 0, "R9");
    drain();
    post(0, 0, 8, 0, 0, "R10"); drain();
    repeat (3) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule